// File: doc/BRIEF.md
# Guarded Dual-Clock FIFO

This block moves data words from a fast write clock domain into a slower read clock domain that has no fixed relation to it. Storage is a small two-port array. Each side keeps its own pointer. Each pointer crosses into the other domain in Gray code through a chain of flip-flops. The read side uses its copy of the write pointer to decide when the buffer is empty. The write side uses its copy of the read pointer to decide when the buffer is full.

The block keeps its output stream predictable when the logic around it misbehaves. A write that arrives while the buffer is full is dropped. A read that arrives while it is empty leaves the read pointer where it is and returns an all-zero word. Each of these events raises a sticky flag in its own domain, and that flag stays set until a clear input in the same domain removes it. Two early-warning outputs give the fill level seen from each side: one near the top of the buffer and one near the bottom.

The parameters set the word width, the depth (a power of two, default 8 words of 32 bits) and the number of synchronizer stages (default 4, at least 2). Each domain has an active-low reset that asserts at once and releases on its own clock.

Top module: `async_guard_fifo`

## Requirements
- R1: While both resets are held and just after they release, the outputs read as follows: wr_full_o=0, wr_afull_o=0, wr_ovf_o=0, rd_empty_o=1, rd_aempty_o=1, rd_unf_o=0, rd_valid_o=0.
- R2: When no write is dropped, the words come out in the order they were accepted, each exactly once.
- R3: A write request made while wr_full_o=1 is discarded. Nothing stored changes, and the words later read out are only the ones accepted before and after it.
- R4: wr_ovf_o becomes 1 on the write-clock edge after a discarded write. It stays 1 until a write-clock edge with wr_ovf_clr_i=1 and no new discarded write.
- R5: A read request made while rd_empty_o=1 leaves the read pointer unchanged. One read-clock cycle later it gives rd_data_o equal to all zeros with rd_valid_o=0.
- R6: rd_unf_o becomes 1 on the read-clock edge after a read request made on empty. It stays 1 until a read-clock edge with rd_unf_clr_i=1 and no new such request.
- R7: A read request accepted while rd_empty_o=0 gives the next word with rd_valid_o=1 exactly one read-clock cycle later. With no request, rd_valid_o=0.
- R8: wr_full_o is 1 when the write side sees DEPTH words stored. After reads free space and the read pointer has crossed the synchronizer, wr_full_o returns to 0.
- R9: wr_afull_o is 1 when the write-side occupancy is at least 7/8 of DEPTH (7 words at depth 8), and 0 below that.
- R10: rd_aempty_o is 1 when the read-side occupancy is at most DEPTH/8 (1 word at depth 8). rd_empty_o is 1 when it is zero.
- R11: With writes in a repeating two-of-three cadence and reads that stall now and then, so that the buffer overflows again and again, the words read are exactly the accepted words in order. No word is repeated, skipped or reordered after an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-domain clock |
| wr_rst_ni | input | 1 | Write-domain reset, active low, asynchronous assert |
| wr_data_i | input | DATA_W | Word to store |
| wr_req_i | input | 1 | Write request |
| wr_ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| wr_full_o | output | 1 | Buffer full as seen from the write side |
| wr_afull_o | output | 1 | Occupancy at or above 7/8 of depth |
| wr_ovf_o | output | 1 | Sticky: a write was dropped |
| rd_clk_i | input | 1 | Read-domain clock |
| rd_rst_ni | input | 1 | Read-domain reset, active low, asynchronous assert |
| rd_req_i | input | 1 | Read request |
| rd_unf_clr_i | input | 1 | Clears the sticky underflow flag |
| rd_data_o | output | DATA_W | Registered read word, zero after a read on empty |
| rd_valid_o | output | 1 | rd_data_o holds a real word |
| rd_empty_o | output | 1 | Buffer empty as seen from the read side |
| rd_aempty_o | output | 1 | Occupancy at or below 1/8 of depth |
| rd_unf_o | output | 1 | Sticky: a read was requested on empty |

## Verification
The bench builds the block with its defaults: 32-bit words, 8 entries and 4 synchronizer stages. With only 8 entries, a read stall of a few cycles fills the buffer, so the bench can force many overflow episodes and confirm each time that the stream keeps its order. The two thresholds land on 7 words and 1 word, so the bench can check both edges of each flag by counting words. The four stages make the pointer crossing take several cycles, which exposes the lag between one side's view of occupancy and the other's.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;
  localparam int unsigned PTR_MAX = 32;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
module afifo_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= '0;
        else         chain_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/afifo_mem.sv
`timescale 1ns/1ps
module afifo_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  // read address is only used once the written word has crossed via the pointer sync
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/afifo_wr_ctrl.sv
`timescale 1ns/1ps
module afifo_wr_ctrl #(
  parameter int unsigned AW     = 3,
  parameter int unsigned AF_LVL = 7,
  localparam int unsigned PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          ovf_clr_i,
  input  logic [PW-1:0] rq_gray_i,
  output logic [PW-1:0] ptr_gray_o,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic          full_o,
  output logic          afull_o,
  output logic          ovf_o
);
  import afifo_pkg::*;

  localparam logic [PW-1:0] FULL_DIFF = {2'b11, {(AW-1){1'b0}}};
  localparam logic [PW-1:0] AF_CMP    = PW'(AF_LVL);

  logic [PW-1:0] bin_q, gray_q, bin_nxt, rq_bin, occ;
  ptr_t          gray_w, rq_bin_w;

  assign full_o   = (gray_q ^ rq_gray_i) == FULL_DIFF;
  assign we_o     = req_i & ~full_o;
  assign bin_nxt  = bin_q + PW'(1);
  assign gray_w   = bin2gray(ptr_t'(bin_nxt));
  assign rq_bin_w = gray2bin(ptr_t'(rq_gray_i));
  assign rq_bin   = rq_bin_w[PW-1:0];
  assign occ      = bin_q - rq_bin;
  assign afull_o  = occ >= AF_CMP;
  assign addr_o   = bin_q[AW-1:0];
  assign ptr_gray_o = gray_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (we_o) begin
      bin_q  <= bin_nxt;
      gray_q <= gray_w[PW-1:0];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 ovf_o <= 1'b0;
    else if (req_i && full_o)    ovf_o <= 1'b1;
    else if (ovf_clr_i)          ovf_o <= 1'b0;

  assert_drop_holds_ptr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && full_o) |=> $stable(bin_q));
  assert_wr_gray_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
  assert_ovf_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  assert_ovf_on_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && full_o) |=> ovf_o);
  assert_occ_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= PW'(1 << AW));
endmodule

// File: rtl/afifo_rd_ctrl.sv
`timescale 1ns/1ps
module afifo_rd_ctrl #(
  parameter int unsigned AW     = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AE_LVL = 1,
  localparam int unsigned PW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              unf_clr_i,
  input  logic [PW-1:0]     wq_gray_i,
  input  logic [DATA_W-1:0] mem_q_i,
  output logic [AW-1:0]     addr_o,
  output logic [PW-1:0]     ptr_gray_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              unf_o
);
  import afifo_pkg::*;

  localparam logic [PW-1:0] AE_CMP = PW'(AE_LVL);

  logic [PW-1:0] bin_q, gray_q, bin_nxt, wq_bin, occ;
  logic          take;
  ptr_t          gray_w, wq_bin_w;

  assign empty_o  = gray_q == wq_gray_i;
  assign take     = req_i & ~empty_o;
  assign bin_nxt  = bin_q + PW'(1);
  assign gray_w   = bin2gray(ptr_t'(bin_nxt));
  assign wq_bin_w = gray2bin(ptr_t'(wq_gray_i));
  assign wq_bin   = wq_bin_w[PW-1:0];
  assign occ      = wq_bin - bin_q;
  assign aempty_o = occ <= AE_CMP;
  assign addr_o   = bin_q[AW-1:0];
  assign ptr_gray_o = gray_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (take) begin
      bin_q  <= bin_nxt;
      gray_q <= gray_w[PW-1:0];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= take;
      if (take)       data_o <= mem_q_i;
      else if (req_i) data_o <= '0;   // filler on empty
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 unf_o <= 1'b0;
    else if (req_i && empty_o)   unf_o <= 1'b1;
    else if (unf_clr_i)          unf_o <= 1'b0;

  assert_empty_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && empty_o) |=> (data_o == '0) && !valid_o && $stable(bin_q));
  assert_rd_gray_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
  assert_unf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_o && !unf_clr_i) |=> unf_o);
  assert_take_gives_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !empty_o) |=> valid_o);
  assert_empty_implies_aempty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> aempty_o);
endmodule

// File: rtl/async_guard_fifo.sv
`timescale 1ns/1ps
module async_guard_fifo #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned SYNC_STAGES = 4
) (
  input  logic              wr_clk_i,
  input  logic              wr_rst_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_req_i,
  input  logic              wr_ovf_clr_i,
  output logic              wr_full_o,
  output logic              wr_afull_o,
  output logic              wr_ovf_o,
  input  logic              rd_clk_i,
  input  logic              rd_rst_ni,
  input  logic              rd_req_i,
  input  logic              rd_unf_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_empty_o,
  output logic              rd_aempty_o,
  output logic              rd_unf_o
);
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned PW     = AW + 1;
  localparam int unsigned AF_LVL = (DEPTH * 7) / 8;
  localparam int unsigned AE_LVL = DEPTH / 8;

  if (SYNC_STAGES < 2) begin : g_bad_sync
    $error("SYNC_STAGES must be at least 2");
  end
  if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
    $error("DEPTH must be a power of two, at least 4");
  end

  logic [PW-1:0]     wr_gray, rd_gray, wq_gray_rd, rq_gray_wr;
  logic [AW-1:0]     waddr, raddr;
  logic              we;
  logic [DATA_W-1:0] mem_rdata;

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .d_i(wr_gray), .q_o(wq_gray_rd));

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .d_i(rd_gray), .q_o(rq_gray_wr));

  afifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk_i(wr_clk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .raddr_i(raddr), .rdata_o(mem_rdata));

  afifo_wr_ctrl #(.AW(AW), .AF_LVL(AF_LVL)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .req_i(wr_req_i), .ovf_clr_i(wr_ovf_clr_i),
    .rq_gray_i(rq_gray_wr), .ptr_gray_o(wr_gray), .addr_o(waddr), .we_o(we),
    .full_o(wr_full_o), .afull_o(wr_afull_o), .ovf_o(wr_ovf_o));

  afifo_rd_ctrl #(.AW(AW), .DATA_W(DATA_W), .AE_LVL(AE_LVL)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .req_i(rd_req_i), .unf_clr_i(rd_unf_clr_i),
    .wq_gray_i(wq_gray_rd), .mem_q_i(mem_rdata), .addr_o(raddr), .ptr_gray_o(rd_gray),
    .data_o(rd_data_o), .valid_o(rd_valid_o), .empty_o(rd_empty_o),
    .aempty_o(rd_aempty_o), .unf_o(rd_unf_o));
endmodule

// File: tb/async_guard_fifo_test.sv
`timescale 1ns/1ps
module async_guard_fifo_test;
  localparam int unsigned DW = 32;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_req = 1'b0, wr_ovf_clr = 1'b0;
  logic          rd_req = 1'b0, rd_unf_clr = 1'b0;
  logic          wr_full, wr_afull, wr_ovf;
  logic [DW-1:0] rd_data;
  logic          rd_valid, rd_empty, rd_aempty, rd_unf;

  int unsigned n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  bit wr_done = 1'b0;

  always #1.359 wr_clk = ~wr_clk;   // ~368 MHz
  always #2.041 rd_clk = ~rd_clk;   // ~245 MHz

  async_guard_fifo uut (
    .wr_clk_i(wr_clk), .wr_rst_ni(wr_rst_n), .wr_data_i(wr_data), .wr_req_i(wr_req),
    .wr_ovf_clr_i(wr_ovf_clr), .wr_full_o(wr_full), .wr_afull_o(wr_afull), .wr_ovf_o(wr_ovf),
    .rd_clk_i(rd_clk), .rd_rst_ni(rd_rst_n), .rd_req_i(rd_req), .rd_unf_clr_i(rd_unf_clr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_empty_o(rd_empty),
    .rd_aempty_o(rd_aempty), .rd_unf_o(rd_unf));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a write negedge; returns at the next one
  task automatic wr_cycle(input bit req, input logic [DW-1:0] d);
    bit drop;
    wr_req = req; wr_data = d;
    drop = req && wr_full;
    if (req && !wr_full) exp_q.push_back(d);
    @(negedge wr_clk);
    wr_req = 1'b0;
    if (drop) check(wr_ovf == 1'b1, "R4", "ovf after drop", DW'(wr_ovf), 1);
  endtask

  // called at a read negedge; returns at the next one with the result checked
  task automatic rd_cycle(input bit req);
    bit take, on_empty;
    logic [DW-1:0] e;
    rd_req = req;
    take = req && !rd_empty;
    on_empty = req && rd_empty;
    @(negedge rd_clk);
    rd_req = 1'b0;
    if (take) begin
      e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
      check(rd_valid == 1'b1, "R7", "valid after read", DW'(rd_valid), 1);
      check(rd_data == e, "R2", "read order", rd_data, e);
    end else if (on_empty) begin
      check(rd_valid == 1'b0 && rd_data == '0, "R5", "filler on empty", rd_data, 0);
      check(rd_unf == 1'b1, "R6", "unf after empty read", DW'(rd_unf), 1);
    end else begin
      check(rd_valid == 1'b0, "R7", "no valid when idle", DW'(rd_valid), 0);
    end
  endtask

  function automatic bit cadence_on(int unsigned i);
    return (i % 3) != 2;
  endfunction

  initial begin
    repeat (150000) @(posedge wr_clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge rd_clk);
    check(wr_full == 0 && wr_afull == 0 && wr_ovf == 0, "R1", "write side in reset",
          {wr_full, wr_afull, wr_ovf}, 0);
    check(rd_empty == 1 && rd_aempty == 1 && rd_unf == 0 && rd_valid == 0, "R1",
          "read side in reset", {rd_empty, rd_aempty, rd_unf, rd_valid}, 4'b1100);
    @(negedge wr_clk); wr_rst_n = 1'b1;
    @(negedge rd_clk); rd_rst_n = 1'b1;
    repeat (2) @(negedge rd_clk);
    check(rd_empty == 1 && rd_aempty == 1 && rd_unf == 0, "R1", "read side after reset",
          {rd_empty, rd_aempty, rd_unf}, 3'b110);
    @(negedge wr_clk);
    check(wr_full == 0 && wr_ovf == 0, "R1", "write side after reset", {wr_full, wr_ovf}, 0);

    // read on empty, stickiness, clear
    @(negedge rd_clk);
    rd_cycle(1'b1);
    rd_cycle(1'b0);
    check(rd_unf == 1'b1, "R6", "unf sticky", DW'(rd_unf), 1);
    rd_unf_clr = 1'b1; @(negedge rd_clk); rd_unf_clr = 1'b0;
    check(rd_unf == 1'b0, "R6", "unf cleared", DW'(rd_unf), 0);

    // fill with no reads: afull at 7, full at 8, then drops
    @(negedge wr_clk);
    for (int i = 0; i < 6; i++) wr_cycle(1'b1, 32'hA000_0000 + DW'(i));
    check(wr_afull == 1'b0, "R9", "afull low at 6", DW'(wr_afull), 0);
    wr_cycle(1'b1, 32'hA000_0006);
    check(wr_afull == 1'b1 && wr_full == 1'b0, "R9", "afull high at 7", {wr_afull, wr_full}, 2'b10);
    wr_cycle(1'b1, 32'hA000_0007);
    check(wr_full == 1'b1, "R8", "full at depth", DW'(wr_full), 1);
    for (int i = 0; i < 3; i++) wr_cycle(1'b1, 32'hDEAD_0000 + DW'(i));
    check(exp_q.size() == 8, "R3", "dropped writes not queued", DW'(exp_q.size()), 8);
    wr_cycle(1'b0, '0);
    check(wr_ovf == 1'b1, "R4", "ovf sticky", DW'(wr_ovf), 1);
    wr_ovf_clr = 1'b1; @(negedge wr_clk); wr_ovf_clr = 1'b0;
    check(wr_ovf == 1'b0, "R4", "ovf cleared", DW'(wr_ovf), 0);

    // drain with threshold checks on the read side
    repeat (8) @(negedge rd_clk);
    check(rd_empty == 0 && rd_aempty == 0, "R10", "aempty low at 8", {rd_empty, rd_aempty}, 0);
    for (int i = 0; i < 9; i++) begin
      rd_cycle(1'b1);
      check(rd_aempty == (exp_q.size() <= 1), "R10", "aempty vs occupancy",
            DW'(rd_aempty), DW'(exp_q.size() <= 1));
      check(rd_empty == (exp_q.size() == 0), "R10", "empty vs occupancy",
            DW'(rd_empty), DW'(exp_q.size() == 0));
    end
    check(exp_q.size() == 0, "R3", "all accepted words seen", DW'(exp_q.size()), 0);
    repeat (12) @(negedge wr_clk);
    check(wr_full == 1'b0 && wr_afull == 1'b0, "R8", "full released after reads",
          {wr_full, wr_afull}, 0);
    wr_ovf_clr = 1'b1; @(negedge wr_clk); wr_ovf_clr = 1'b0;

    // cadenced writes with stalling reads, repeated overflow episodes
    fork
      begin
        @(negedge wr_clk);
        for (int i = 0; i < 3000; i++) wr_cycle(cadence_on(i), $urandom);
        wr_done = 1'b1;
      end
      begin
        @(negedge rd_clk);
        for (int j = 0; !wr_done; j++) begin
          if ((j % 150) >= 135) rd_cycle(1'b0);
          else rd_cycle(($urandom % 16) != 0);
        end
      end
    join
    check(wr_ovf == 1'b1, "R11", "overflow episodes occurred", DW'(wr_ovf), 1);
    @(negedge rd_clk);
    for (int k = 0; k < 40 && exp_q.size() > 0; k++) rd_cycle(1'b1);
    check(exp_q.size() == 0, "R11", "stream fully drained in order", DW'(exp_q.size()), 0);
    repeat (8) @(negedge rd_clk);
    check(rd_empty == 1'b1, "R11", "empty after drain", DW'(rd_empty), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule